// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block serves the transmit side of an Ethernet controller. Software places a ring of eight-byte buffer descriptors in system memory and marks each one ready. A kick pulse then starts the walker. It fetches each ready descriptor, reads the buffer that descriptor points to one 32-bit word at a time, and streams the bytes out on a valid/ready byte interface. Descriptors are joined into one frame until a descriptor flagged as last is reached. After each descriptor is consumed, its ready flag is cleared in memory, which returns it to software.

A frame is capped at a fixed maximum size. Bytes beyond the cap are dropped and an error pulse is raised. The ring pointer follows a wrap flag back to the ring base, and it keeps its position between kicks. A single kick handles a bounded number of descriptors. A kick that arrives during a walk is remembered, so that descriptors readied late are not missed. The register file, the MAC and CRC generation lie outside this block.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the block makes no memory request, presents no stream byte and raises no event pulse.
- R2: A walk starts only on a kick sampled while `enable` is high. A kick while `enable` is low causes no memory request.
- R3: A descriptor is two words. The word at the pointer holds flags in bits 31:16 and byte length in bits 15:0. The word at pointer+4 holds the buffer byte address. Ready is flag bit 15 (word bit 31), wrap is flag bit 13 (word bit 29) and last is flag bit 11 (word bit 27). The walk stops at the first descriptor whose ready bit is clear.
- R4: Buffer bytes are streamed in ascending address order for any alignment and length. The byte at address a is bits [31-8*(a mod 4) -: 8] of the word at a with its low two bits cleared.
- R5: Bytes of consecutive descriptors form one frame that ends at a descriptor with last set. `tx_first` marks the frame's first byte and `tx_last` marks its final byte, and `ev_frame_done` pulses once per frame, also for a frame of zero bytes.
- R6: A frame carries at most MAX_FRAME bytes (default 2032). A descriptor that would exceed this limit is clipped to the room left, its excess bytes are not streamed, and `ev_babble` pulses once.
- R7: Each consumed descriptor's first word is written back with the ready bit cleared and the other flags and the length unchanged, followed by one `ev_buf_done` pulse.
- R8: The next descriptor address is the ring base if wrap is set, and otherwise the current address plus 8. The pointer persists from one walk to the next.
- R9: A `base_load` pulse reloads the descriptor pointer with `ring_base`, with its low two bits forced to zero.
- R10: One walk consumes at most MAX_DESC descriptors (default 1024). A further kick continues from where the walk stopped.
- R11: While `tx_valid` is high and `tx_ready` is low, the byte and its marks are held. A memory request is held with a stable address until `mem_ready`.
- R12: A kick that arrives while a walk is in progress, including in the cycle the walk stops, starts a new walk from the current pointer once the present one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; gates the start of a walk |
| kick | input | 1 | One-cycle pulse requesting a walk |
| base_load | input | 1 | Pulse: reload the pointer from `ring_base` |
| ring_base | input | ADDR_W | Ring start byte address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Request accepted this cycle |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_first | output | 1 | Byte is the first of a frame |
| tx_last | output | 1 | Byte is the last of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| ev_buf_done | output | 1 | Pulse: a descriptor was handed back |
| ev_frame_done | output | 1 | Pulse: a frame was completed |
| ev_babble | output | 1 | Pulse: a descriptor was clipped by the frame limit |

## Verification
Two things can happen in the same clock cycle: a fresh kick, and the walker accepting the flags word of a descriptor that is not ready. In that cycle the walk ends and a new one is requested at once. The bench provokes this by holding memory ready and pulsing the kick exactly while the stop descriptor's flags read is on the bus. It judges the result by counting reads of that address, which must be fetched twice. Stream and memory stalls are drawn from a pseudo-random pattern throughout, so byte hand-off under back-pressure is also exercised in every frame test.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int DESC_BYTES = 8;
  localparam int FLG_READY  = 15;
  localparam int FLG_WRAP   = 13;
  localparam int FLG_LAST   = 11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_BPTR, ST_FETCH, ST_BYTE, ST_FLUSH, ST_WBACK
  } walk_st_e;
endpackage

// File: rtl/tx_frame_meter.sv
module tx_frame_meter #(
  parameter int MAX_FRAME = 2032,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             close,
  input  logic [LEN_W-1:0] desc_len,
  output logic [LEN_W-1:0] eff_len,
  output logic             clipped
);
  localparam int FILL_W = $clog2(MAX_FRAME + 1);

  logic [FILL_W-1:0] fill_q, fill_d;
  logic [31:0]       room;

  always_comb begin
    room    = 32'(MAX_FRAME) - 32'(fill_q);
    clipped = 32'(desc_len) > room;
    eff_len = clipped ? LEN_W'(room) : desc_len;
    fill_d  = fill_q;
    if (close)     fill_d = '0;
    else if (take) fill_d = fill_q + FILL_W'(eff_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else if (take || close) fill_q <= fill_d;
  end

  AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(fill_q) <= 32'(MAX_FRAME)); // R6
endmodule

// File: rtl/tx_byte_out.sv
module tx_byte_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_v,
  input  logic [7:0] push_byte,
  output logic       push_ok,
  input  logic       flush,
  output logic       flush_done,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  output logic       tx_first,
  output logic       tx_last,
  input  logic       tx_ready
);
  logic [7:0] hold_q, hold_d;
  logic       full_q, full_d, first_q, first_d, sof_q, sof_d;

  always_comb begin
    tx_valid   = full_q && (push_v || flush);
    tx_data    = hold_q;
    tx_first   = first_q;
    tx_last    = full_q && flush;
    push_ok    = !full_q || tx_ready;
    flush_done = flush && (!full_q || tx_ready);
    hold_d  = hold_q;
    full_d  = full_q;
    first_d = first_q;
    sof_d   = sof_q;
    if (push_v && push_ok) begin
      hold_d  = push_byte;
      full_d  = 1'b1;
      first_d = sof_q;
      sof_d   = 1'b0;
    end else if (flush_done) begin
      full_d = 1'b0;
      sof_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      first_q <= 1'b0;
      sof_q   <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      first_q <= first_d;
      sof_q   <= sof_d;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_first)); // R11
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine #(
  parameter int ADDR_W    = 32,
  parameter int MAX_DESC  = 1024,
  parameter int MAX_FRAME = 2032
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              kick,
  input  logic              base_load,
  input  logic [ADDR_W-1:0] ring_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  output logic              tx_first,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              ev_buf_done,
  output logic              ev_frame_done,
  output logic              ev_babble
);
  import tx_ring_pkg::*;
  localparam int LEN_W = 16;
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  logic [1:0] rs_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, bptr_q, bptr_d, base_al;
  logic [15:0]       flg_q, flg_d, wb_flags;
  logic [LEN_W-1:0]  len_q, len_d, rem_q, rem_d, eff_len;
  logic [31:0]       word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pend_q, pend_d, evb_d, evf_d, eva_d;
  logic              evb_q, evf_q, eva_q;
  logic              acc, take, close, clipped, push_v, push_ok, flush, flush_done;
  logic [7:0]        cur_byte;
  walk_st_e          post_st;

  assign base_al  = ring_base & ~ADDR_W'(3);
  assign acc      = mem_req && mem_ready;
  assign cur_byte = 8'(word_q >> {~bptr_q[1:0], 3'b000});
  assign post_st  = flg_q[FLG_LAST] ? ST_FLUSH : ST_WBACK;

  always_comb begin
    wb_flags            = flg_q;
    wb_flags[FLG_READY] = 1'b0;
    mem_req   = (st_q == ST_HDR) || (st_q == ST_BPTR) || (st_q == ST_FETCH) || (st_q == ST_WBACK);
    mem_we    = (st_q == ST_WBACK);
    mem_wdata = {wb_flags, len_q};
    case (st_q)
      ST_BPTR:  mem_addr = cur_q + ADDR_W'(4);
      ST_FETCH: mem_addr = bptr_q & ~ADDR_W'(3);
      default:  mem_addr = cur_q;
    endcase
  end

  always_comb begin
    st_d = st_q;  cur_d = cur_q;  bptr_d = bptr_q;  flg_d = flg_q;
    len_d = len_q;  rem_d = rem_q;  word_d = word_q;  cnt_d = cnt_q;
    pend_d = pend_q;  evb_d = 1'b0;  evf_d = 1'b0;  eva_d = 1'b0;
    take = 1'b0;  close = 1'b0;  push_v = 1'b0;  flush = 1'b0;
    case (st_q)
      ST_IDLE: if (enable && (kick || pend_q)) begin
        st_d = ST_HDR;  cnt_d = '0;  pend_d = 1'b0;
      end
      ST_HDR: if (acc) begin
        if (!mem_rdata[16+FLG_READY]) st_d = ST_IDLE;
        else begin
          flg_d = mem_rdata[31:16];  len_d = mem_rdata[15:0];
          take  = 1'b1;  rem_d = eff_len;  eva_d = clipped;
          st_d  = ST_BPTR;
        end
      end
      ST_BPTR: if (acc) begin
        bptr_d = mem_rdata[ADDR_W-1:0];
        st_d   = (rem_q == '0) ? post_st : ST_FETCH;
      end
      ST_FETCH: if (acc) begin
        word_d = mem_rdata;  st_d = ST_BYTE;
      end
      ST_BYTE: begin
        push_v = 1'b1;
        if (push_ok) begin
          bptr_d = bptr_q + ADDR_W'(1);
          rem_d  = rem_q - LEN_W'(1);
          if (rem_q == LEN_W'(1))       st_d = post_st;
          else if (bptr_q[1:0] == 2'b11) st_d = ST_FETCH;
        end
      end
      ST_FLUSH: begin
        flush = 1'b1;
        if (flush_done) begin
          close = 1'b1;  evf_d = 1'b1;  st_d = ST_WBACK;
        end
      end
      ST_WBACK: if (acc) begin
        evb_d = 1'b1;
        cnt_d = cnt_q + CNT_W'(1);
        cur_d = flg_q[FLG_WRAP] ? base_al : cur_q + ADDR_W'(DESC_BYTES);
        st_d  = (32'(cnt_q) + 32'd1 >= 32'(MAX_DESC)) ? ST_IDLE : ST_HDR;
      end
      default: st_d = ST_IDLE;
    endcase
    if (kick && enable && st_q != ST_IDLE) pend_d = 1'b1;
    if (base_load) cur_d = base_al;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE;  cur_q <= '0;  bptr_q <= '0;  flg_q <= '0;
      len_q <= '0;  rem_q <= '0;  word_q <= '0;  cnt_q <= '0;
      pend_q <= 1'b0;  evb_q <= 1'b0;  evf_q <= 1'b0;  eva_q <= 1'b0;
    end else begin
      st_q <= st_d;  cur_q <= cur_d;  bptr_q <= bptr_d;  flg_q <= flg_d;
      len_q <= len_d;  rem_q <= rem_d;  word_q <= word_d;  cnt_q <= cnt_d;
      pend_q <= pend_d;  evb_q <= evb_d;  evf_q <= evf_d;  eva_q <= eva_d;
    end
  end

  assign ev_buf_done   = evb_q;
  assign ev_frame_done = evf_q;
  assign ev_babble     = eva_q;

  tx_frame_meter #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W)) meter_i (
    .clk(clk), .rst_n(rst_ns), .take(take), .close(close),
    .desc_len(mem_rdata[15:0]), .eff_len(eff_len), .clipped(clipped));

  tx_byte_out out_i (
    .clk(clk), .rst_n(rst_ns), .push_v(push_v), .push_byte(cur_byte),
    .push_ok(push_ok), .flush(flush), .flush_done(flush_done),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first),
    .tx_last(tx_last), .tx_ready(tx_ready));

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_req && !mem_ready && !base_load |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_BUF_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_ns)
    ev_buf_done |-> $past(mem_req && mem_we && mem_ready)); // R7
  AST_FRAME_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_ns)
    ev_frame_done |-> $past(st_q == ST_FLUSH)); // R5
  AST_DESC_LIMIT: assert property (@(posedge clk) disable iff (!rst_ns)
    32'(cnt_q) <= 32'(MAX_DESC)); // R10
endmodule

// File: tb/tx_ring_engine_tb_top.sv
module tx_ring_engine_tb_top;
  localparam int MAXD = 6;
  localparam int MAXF = 40;
  localparam logic [15:0] F_RDY = 16'h8000, F_WRAP = 16'h2000, F_LAST = 16'h0800;
  // {count, len0, addr0, len1, addr1}
  localparam logic [43:0] VEC [6] = '{
    {4'd1, 8'd5,  12'h101, 8'd0,  12'h000},
    {4'd1, 8'd8,  12'h200, 8'd0,  12'h000},
    {4'd2, 8'd3,  12'h103, 8'd6,  12'h180},
    {4'd2, 8'd30, 12'h140, 8'd20, 12'h242},
    {4'd1, 8'd0,  12'h100, 8'd0,  12'h000},
    {4'd2, 8'd0,  12'h100, 8'd4,  12'h302}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, enable, kick, base_load;
  logic [31:0] ring_base, mem_addr, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ready, tx_valid, tx_first, tx_last, tx_ready;
  logic [7:0] tx_data;
  logic ev_buf_done, ev_frame_done, ev_babble;

  tx_ring_engine #(.MAX_DESC(MAXD), .MAX_FRAME(MAXF)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick), .base_load(base_load),
    .ring_base(ring_base), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last),
    .tx_ready(tx_ready), .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done),
    .ev_babble(ev_babble));

  logic [31:0] mem [256];
  assign mem_rdata = mem[mem_addr[9:2]];

  logic [15:0] lf = 16'hACE1;
  logic rdy_all = 1'b0;
  always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  assign tx_ready  = lf[0] | lf[2];
  assign mem_ready = rdy_all | lf[1] | lf[4];

  logic clr = 1'b0;
  logic [7:0] cap_b [64];
  logic cap_f [64];
  logic cap_l [64];
  int cap_n, nrd, nwatch, nbuf, nfrm, nbab, nfirst, nlast, viol, nstall;
  logic [31:0] first_rd, watch_addr;
  logic pv_stall, pm_stall;
  logic [7:0] pv_data;
  logic [31:0] pm_addr;

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    pv_stall <= tx_valid && !tx_ready;
    pv_data  <= tx_data;
    pm_stall <= mem_req && !mem_ready;
    pm_addr  <= mem_addr;
    if (pv_stall && (!tx_valid || tx_data != pv_data)) viol <= viol + 1;
    if (pm_stall && (!mem_req || mem_addr != pm_addr)) viol <= viol + 1;
    if (tx_valid && !tx_ready) nstall <= nstall + 1;
    if (clr) begin
      cap_n <= 0; nrd <= 0; nwatch <= 0; nbuf <= 0; nfrm <= 0; nbab <= 0;
      nfirst <= 0; nlast <= 0; first_rd <= 32'hFFFF_FFFF;
    end else begin
      if (mem_req && mem_ready && !mem_we) begin
        nrd <= nrd + 1;
        if (nrd == 0) first_rd <= mem_addr;
        if (mem_addr == watch_addr) nwatch <= nwatch + 1;
      end
      if (tx_valid && tx_ready) begin
        if (cap_n < 64) begin
          cap_b[cap_n] <= tx_data; cap_f[cap_n] <= tx_first; cap_l[cap_n] <= tx_last;
        end
        cap_n <= cap_n + 1;
        if (tx_first) nfirst <= nfirst + 1;
        if (tx_last)  nlast  <= nlast + 1;
      end
      if (ev_buf_done)   nbuf <= nbuf + 1;
      if (ev_frame_done) nfrm <= nfrm + 1;
      if (ev_babble)     nbab <= nbab + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'hC3;
  endfunction

  task automatic put_desc(input int p, input logic [15:0] f, input logic [15:0] l, input int a);
    mem[p >> 2]       = {f, l};
    mem[(p >> 2) + 1] = 32'(a);
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  task automatic load(input logic [31:0] b);
    @(negedge clk) begin ring_base = b; base_load = 1'b1; end
    @(negedge clk) base_load = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 16) begin
      @(negedge clk);
      q = (mem_req || tx_valid) ? 0 : q + 1;
    end
  endtask

  task automatic chk_bytes(input int base_a, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap_b[i] != pat(base_a + i)) bad++;
    chk(bad == 0 && cap_n == n, tag, cap_n, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  logic [7:0] eb [64];
  initial begin
    rst_n = 1'b0; enable = 1'b0; kick = 1'b0; base_load = 1'b0;
    ring_base = '0; watch_addr = 32'hFFFF_FFFF; viol = 0; nstall = 0;
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(4*w), pat(4*w+1), pat(4*w+2), pat(4*w+3)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear();
    repeat (4) @(negedge clk);
    // R1: quiet after reset
    chk(!mem_req && !tx_valid && !ev_buf_done && !ev_frame_done && !ev_babble,
        "R1 idle after reset", int'(mem_req) + int'(tx_valid), 0);

    // R2: kick while disabled
    put_desc(0, F_RDY | F_LAST, 16'd2, 32'h110);
    pulse_kick();
    repeat (20) @(negedge clk);
    chk(nrd == 0, "R2 kick ignored while disabled", nrd, 0);
    enable = 1'b1;

    // table of frame vectors: R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      int nd, l0, a0, l1, a1, e, clip;
      nd = int'(VEC[v][43:40]); l0 = int'(VEC[v][39:32]); a0 = int'(VEC[v][31:20]);
      l1 = int'(VEC[v][19:12]); a1 = int'(VEC[v][11:0]);
      put_desc(0, (nd == 1) ? (F_RDY | F_LAST) : F_RDY, 16'(l0), a0);
      if (nd == 2) put_desc(8, F_RDY | F_LAST, 16'(l1), a1);
      put_desc(nd * 8, 16'h0000, 16'd0, 0);
      load(32'h3);
      clear();
      pulse_kick();
      wait_quiet();
      e = 0; clip = 0;
      for (int i = 0; i < l0; i++) if (e < MAXF) begin eb[e] = pat(a0 + i); e++; end
      for (int i = 0; i < l1 && nd == 2; i++) begin
        if (e < MAXF) begin eb[e] = pat(a1 + i); e++; end else clip = 1;
      end
      begin
        int bad = 0;
        for (int i = 0; i < e; i++) if (cap_b[i] != eb[i]) bad++;
        chk(bad == 0 && cap_n == e, "R4 byte order and lanes", cap_n, e);
      end
      if (e > 0) begin
        chk(cap_f[0] && nfirst == 1, "R5 first mark", nfirst, 1);
        chk(cap_l[e-1] && nlast == 1, "R5 last mark", nlast, 1);
      end else
        chk(nfirst == 0 && nlast == 0, "R5 no marks on empty frame", nfirst + nlast, 0);
      chk(nfrm == 1, "R5 frame done pulse", nfrm, 1);
      chk(nbab == clip, "R6 babble pulse", nbab, clip);
      chk(nbuf == nd, "R7 buffer done pulses", nbuf, nd);
      chk(mem[0] == {((nd == 1) ? F_LAST : 16'h0000), 16'(l0)}, "R7 write-back word",
          int'(mem[0][31:16]), int'((nd == 1) ? F_LAST : 16'h0000));
    end

    // R9 and R3: base load masks low bits; stop at not-ready descriptor
    put_desc(8, 16'h0000, 16'd0, 0);
    load(32'hB);
    clear();
    pulse_kick();
    wait_quiet();
    chk(first_rd == 32'h8, "R9 pointer reload with low bits cleared", int'(first_rd), 8);
    chk(nrd == 1 && nbuf == 0, "R3 stop at ready clear", nrd, 1);

    // R8: persistence and wrap
    put_desc(0, F_RDY | F_LAST, 16'd2, 32'h110);
    put_desc(8, 16'h0000, 16'd0, 0);
    load(32'h0);
    clear(); pulse_kick(); wait_quiet();
    chk_bytes(32'h110, 2, "R8 first frame");
    put_desc(8, F_RDY | F_LAST | F_WRAP, 16'd3, 32'h120);
    clear(); pulse_kick(); wait_quiet();
    chk_bytes(32'h120, 3, "R8 pointer kept between walks");
    chk(first_rd == 32'h8, "R8 resume address", int'(first_rd), 8);
    put_desc(0, F_RDY | F_LAST, 16'd1, 32'h130);
    clear(); pulse_kick(); wait_quiet();
    chk(first_rd == 32'h0, "R8 wrap to base", int'(first_rd), 0);
    chk_bytes(32'h130, 1, "R8 wrapped descriptor data");

    // R10: descriptor limit per walk
    for (int i = 0; i < 8; i++) put_desc(8 * i, F_RDY | F_LAST, 16'd1, 32'h150 + i);
    put_desc(64, 16'h0000, 16'd0, 0);
    load(32'h0);
    clear(); pulse_kick(); wait_quiet();
    chk(nbuf == MAXD, "R10 walk capped", nbuf, MAXD);
    clear(); pulse_kick(); wait_quiet();
    chk(nbuf == 2, "R10 next kick continues", nbuf, 2);

    // R12: kick coincident with stop
    rdy_all = 1'b1;
    put_desc(0, F_RDY | F_LAST, 16'd4, 32'h160);
    put_desc(8, 16'h0000, 16'd0, 0);
    load(32'h0);
    watch_addr = 32'h8;
    clear();
    pulse_kick();
    while (!(mem_req && !mem_we && mem_addr == 32'h8)) @(negedge clk);
    kick = 1'b1;
    @(negedge clk) kick = 1'b0;
    wait_quiet();
    chk(nwatch == 2, "R12 coincident kick re-walks", nwatch, 2);
    chk(nbuf == 1, "R12 single hand-back", nbuf, 1);
    rdy_all = 1'b0;

    // R11: back-pressure seen and honoured
    chk(nstall > 0, "R11 stalls occurred", nstall, 1);
    chk(viol == 0, "R11 held under stall", viol, 0);
    summary();
  end
endmodule